// File: doc/BRIEF.md
# Sieve Prime Marking Engine

This block finds all primes from 2 up to a run-time limit N with the sieve of Eratosthenes. It keeps one mark flag per number from 0 to a build-time maximum in flip-flops. A sequencer walks candidate values upward. When it reaches an unmarked candidate m, it marks m·m, m·m+m, m·m+2m and so on up to N, one flag per clock. When the square of the next candidate is larger than N, sieving stops, and every number that is still unmarked is prime.

A run starts with a one-cycle `start` pulse that carries the limit on `n_in`. The engine raises `busy` while it works and gives a single-cycle `done` when it finishes. After that, a streaming port delivers the primes in ascending order with a valid/ready handshake and flags the final prime. A combinational read port returns the mark flag of any address at any time, so the caller can also inspect the sieve directly.

Top module: `sieve_engine`

## Requirements
- R1: After a run with limit N, `rd_mark` reads 0 for each prime k in 2..N and 1 for each composite in that range. Addresses 0 and 1 read 1. Addresses N+1..MAX_N read 0. Any address above MAX_N reads 1.
- R2: Sieving costs one clock per candidate examined, for every candidate c with c·c ≤ N. Each prime m also costs one clock per multiple marked, starting at m·m in steps of m. The final candidate, whose square exceeds N, costs one more clock. `done` is therefore high exactly that many cycles after the clock edge that accepts `start`.
- R3: `busy` is high from the cycle after an accepted start until completion. `done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R4: A `start` pulse arriving while `busy` is high has no effect on the limit, the timing or the result of the run in progress.
- R5: In the cycles after `done`, `out_data` presents each prime ≤ N exactly once, in ascending order. A transfer happens on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, a presented value stays held.
- R6: `out_last` is high together with the largest prime ≤ N and with no other value. After that transfer, `out_valid` stays low.
- R7: A limit of 0 or 1 completes one cycle after the accepted start, and no value is ever streamed.
- R8: A limit on `n_in` larger than MAX_N runs exactly as a limit of MAX_N.
- R9: During and right after reset, `busy`, `done` and `out_valid` are low and every mark flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run; ignored while busy |
| n_in | input | IDX_W | Upper limit N of the run, sampled with start |
| busy | output | 1 | Sieving in progress |
| done | output | 1 | Single-cycle completion pulse |
| rd_addr | input | IDX_W | Number whose mark flag is read |
| rd_mark | output | 1 | Mark flag of rd_addr (1 = composite or excluded) |
| out_valid | output | 1 | A prime is presented on out_data |
| out_ready | input | 1 | Consumer accepts the presented prime |
| out_data | output | IDX_W | Presented prime |
| out_last | output | 1 | Presented prime is the largest one ≤ N |

## Verification
A second start request can arrive in the same cycle that the sequencer is marking a multiple or scanning a candidate. The bench provokes this by pulsing `start` with a different limit three cycles into an N = 30 run. It then judges the outcome at the ports: the completion cycle must still equal the count predicted for 30, and the read port and the prime stream must still match 30. The bench sweeps every limit from 0 to MAX_N and computes the expected cycle counts and prime sets arithmetically. It drives a ready pattern that stalls the stream at several positions, including on the last prime.

// File: rtl/sieve_pkg.sv
`timescale 1ns/1ps
package sieve_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_MARK = 2'd2
    } phase_e;
endpackage

// File: rtl/sieve_bitvec.sv
`timescale 1ns/1ps
// Mark flag storage: one-cycle bulk initialise plus one flag set per cycle.
module sieve_bitvec #(
    parameter int MAX_N = 64,
    localparam int IDX_W = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             set_i,
    input  logic [IDX_W-1:0] set_idx_i,
    output logic [MAX_N:0]   marks_o
);
    localparam logic [IDX_W-1:0] MAX_V = IDX_W'(MAX_N);

    logic [MAX_N:0] vec_d, vec_q;

    always_comb begin
        vec_d = vec_q;
        if (clear_i) begin
            vec_d    = '0;
            vec_d[0] = 1'b1;
            vec_d[1] = 1'b1;
        end else if (set_i && (set_idx_i <= MAX_V)) begin
            vec_d[set_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '1;
        else        vec_q <= vec_d;
    end

    assign marks_o = vec_q;

    AST_MARK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clear_i) |=> marks_o[$past(set_idx_i)]); // R1

endmodule

// File: rtl/sieve_ctrl.sv
`timescale 1ns/1ps
// Sequencer: candidate scan, square test and multiple marking.
module sieve_ctrl
    import sieve_pkg::*;
#(
    parameter int MAX_N = 64,
    localparam int IDX_W = $clog2(MAX_N + 1),
    localparam int SQ_W  = 2 * IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] n_i,
    input  logic [MAX_N:0]   marks_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             clear_o,
    output logic             set_o,
    output logic [IDX_W-1:0] set_idx_o,
    output logic [IDX_W-1:0] limit_o
);
    localparam logic [IDX_W-1:0] MAX_V = IDX_W'(MAX_N);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] limit;
        logic [IDX_W-1:0] cand;
        logic [IDX_W:0]   idx;
        logic             done;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [SQ_W-1:0] cand_sq;
    logic            cand_marked;
    logic [IDX_W:0]  idx_step;

    always_comb begin
        cand_sq     = {{IDX_W{1'b0}}, s_q.cand} * {{IDX_W{1'b0}}, s_q.cand};
        cand_marked = (s_q.cand <= MAX_V) ? marks_i[s_q.cand] : 1'b1;
        idx_step    = s_q.idx + {1'b0, s_q.cand};

        s_d     = s_q;
        s_d.done = 1'b0;
        clear_o = 1'b0;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    clear_o   = 1'b1;
                    s_d.limit = (n_i > MAX_V) ? MAX_V : n_i;
                    s_d.cand  = IDX_W'(2);
                    s_d.phase = PH_SCAN;
                end
            end
            PH_SCAN: begin
                if (cand_sq > SQ_W'(s_q.limit)) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else if (!cand_marked) begin
                    s_d.idx   = cand_sq[IDX_W:0];
                    s_d.phase = PH_MARK;
                end else begin
                    s_d.cand = s_q.cand + 1'b1;
                end
            end
            PH_MARK: begin
                if (idx_step > {1'b0, s_q.limit}) begin
                    s_d.cand  = s_q.cand + 1'b1;
                    s_d.phase = PH_SCAN;
                end else begin
                    s_d.idx = idx_step;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, limit: '0, cand: '0, idx: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.phase != PH_IDLE);
    assign done_o    = s_q.done;
    assign set_o     = (s_q.phase == PH_MARK);
    assign set_idx_o = s_q.idx[IDX_W-1:0];
    assign limit_o   = s_q.limit;

    AST_MARK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_MARK) |-> (s_q.idx <= {1'b0, s_q.limit})); // R2

    AST_MARK_MULTIPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_MARK) |-> ((s_q.idx % {1'b0, s_q.cand}) == '0)); // R2

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(s_q.limit)); // R4

endmodule

// File: rtl/sieve_emit.sv
`timescale 1ns/1ps
// Prime stream: scans the finished flags upward, one number per cycle.
module sieve_emit #(
    parameter int MAX_N = 64,
    localparam int IDX_W  = $clog2(MAX_N + 1),
    localparam int STEP_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             halt_i,
    input  logic [IDX_W-1:0] limit_i,
    input  logic [MAX_N:0]   marks_i,
    input  logic             out_ready_i,
    output logic             out_valid_o,
    output logic [IDX_W-1:0] out_data_o,
    output logic             out_last_o
);
    localparam logic [STEP_W-1:0] MAX_W = STEP_W'(MAX_N);

    typedef struct packed {
        logic              active;
        logic [STEP_W-1:0] cur;
    } emit_t;

    emit_t s_d, s_q;

    logic              cur_marked;
    logic              in_range;
    logic              more_above;
    logic [STEP_W-1:0] lim_w;

    always_comb begin
        lim_w      = {1'b0, limit_i};
        in_range   = (s_q.cur <= lim_w);
        cur_marked = (s_q.cur <= MAX_W) ? marks_i[s_q.cur[IDX_W-1:0]] : 1'b1;

        more_above = 1'b0;
        for (int i = 2; i <= MAX_N; i++) begin
            if ((STEP_W'(i) > s_q.cur) && (STEP_W'(i) <= lim_w) && !marks_i[i])
                more_above = 1'b1;
        end

        out_valid_o = s_q.active && in_range && !cur_marked;
        out_data_o  = s_q.cur[IDX_W-1:0];
        out_last_o  = out_valid_o && !more_above;

        s_d = s_q;
        if (halt_i) begin
            s_d.active = 1'b0;
        end else if (launch_i) begin
            s_d.active = 1'b1;
            s_d.cur    = STEP_W'(2);
        end else if (s_q.active) begin
            if (!in_range) begin
                s_d.active = 1'b0;
            end else if (!out_valid_o || out_ready_i) begin
                s_d.cur = s_q.cur + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{active: 1'b0, cur: '0};
        else        s_q <= s_d;
    end

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !halt_i) |=> (out_valid_o && $stable(out_data_o))); // R5

    AST_STREAM_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i) |=> (!out_valid_o || (out_data_o > $past(out_data_o)))); // R5

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o); // R6

endmodule

// File: rtl/sieve_engine.sv
`timescale 1ns/1ps
// Top: sequencer, flag storage and prime stream.
module sieve_engine #(
    parameter int MAX_N = 64,
    localparam int IDX_W = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] n_in,
    output logic             busy,
    output logic             done,
    input  logic [IDX_W-1:0] rd_addr,
    output logic             rd_mark,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_data,
    output logic             out_last
);
    localparam logic [IDX_W-1:0] MAX_V = IDX_W'(MAX_N);

    logic [MAX_N:0]   marks;
    logic             clear_w;
    logic             set_w;
    logic [IDX_W-1:0] set_idx_w;
    logic [IDX_W-1:0] limit_w;

    sieve_ctrl #(.MAX_N(MAX_N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .n_i       (n_in),
        .marks_i   (marks),
        .busy_o    (busy),
        .done_o    (done),
        .clear_o   (clear_w),
        .set_o     (set_w),
        .set_idx_o (set_idx_w),
        .limit_o   (limit_w)
    );

    sieve_bitvec #(.MAX_N(MAX_N)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_w),
        .set_i     (set_w),
        .set_idx_i (set_idx_w),
        .marks_o   (marks)
    );

    sieve_emit #(.MAX_N(MAX_N)) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (done),
        .halt_i      (busy),
        .limit_i     (limit_w),
        .marks_i     (marks),
        .out_ready_i (out_ready),
        .out_valid_o (out_valid),
        .out_data_o  (out_data),
        .out_last_o  (out_last)
    );

    assign rd_mark = (rd_addr <= MAX_V) ? marks[rd_addr] : 1'b1;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_BUSY_FALLS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3

    AST_NO_STREAM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !out_valid); // R5

endmodule

// File: tb/sieve_engine_tb.sv
`timescale 1ns/1ps
module sieve_engine_tb;
    localparam int MAX_N = 64;
    localparam int IDX_W = $clog2(MAX_N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] n_in = '0;
    logic [IDX_W-1:0] rd_addr = '0;
    logic             out_ready = 1'b0;
    logic             busy, done, rd_mark, out_valid, out_last;
    logic [IDX_W-1:0] out_data;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sieve_engine #(.MAX_N(MAX_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
        .busy(busy), .done(done), .rd_addr(rd_addr), .rd_mark(rd_mark),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    function automatic bit is_prime(int k);
        if (k < 2) return 1'b0;
        for (int d = 2; d * d <= k; d++) if (k % d == 0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_cycles(int n);
        int c = 0;
        for (int m = 2; m * m <= n; m++) begin
            c++;
            if (is_prime(m)) c += (n - m * m) / m + 1;
        end
        return c + 1;
    endfunction

    function automatic int next_prime(int from, int n);
        for (int k = from; k <= n; k++) if (is_prime(k)) return k;
        return 0;
    endfunction

    function automatic int prime_count(int n);
        int c = 0;
        for (int k = 2; k <= n; k++) if (is_prime(k)) c++;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic run_case(input int n_drive, input bit poke);
        int n_eff;
        int cnt;
        int got;
        int expect_next;
        bit finished;
        bit busy_ok;
        string tag;
        n_eff = (n_drive > MAX_N) ? MAX_N : n_drive;
        cnt = 0; got = 0; finished = 1'b0; busy_ok = 1'b1;
        if (n_eff < 2)          tag = "R7";
        else if (poke)          tag = "R4";
        else if (n_drive > MAX_N) tag = "R8";
        else                    tag = "R2";

        @(negedge clk);
        n_in  = IDX_W'(n_drive);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && cnt < 5000) begin
            if (busy !== 1'b1) busy_ok = 1'b0;
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (poke && cnt == 3) begin
                start = 1'b1;
                n_in  = IDX_W'(10);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(busy_ok, "R3", "busy high throughout run", 0, 1);
        chk(done === 1'b1, "R3", "done reached", int'(done), 1);
        chk(busy === 1'b0, "R3", "busy low in done cycle", int'(busy), 0);
        chk(cnt == exp_cycles(n_eff), tag, "cycles from start to done", cnt, exp_cycles(n_eff));

        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R3", "done lasts one cycle", int'(done), 0);

        expect_next = next_prime(2, n_eff);
        for (int t = 0; t < 4 * MAX_N + 16 && !finished; t++) begin
            out_ready = ((t + n_drive) % 3) != 0;
            #1;
            if (out_valid && out_ready) begin
                chk(int'(out_data) == expect_next, "R5", "streamed prime", int'(out_data), expect_next);
                chk(out_last == (next_prime(expect_next + 1, n_eff) == 0), "R6",
                    "last flag", int'(out_last), int'(next_prime(expect_next + 1, n_eff) == 0));
                got++;
                finished = out_last;
                expect_next = next_prime(expect_next + 1, n_eff);
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk(got == prime_count(n_eff), (n_eff < 2) ? "R7" : "R5", "primes streamed", got, prime_count(n_eff));
        out_ready = 1'b1;
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            #1;
            chk(out_valid === 1'b0, "R6", "no valid after final prime", int'(out_valid), 0);
        end
        out_ready = 1'b0;

        for (int k = 0; k <= MAX_N + 3; k++) begin
            int expv;
            @(negedge clk);
            rd_addr = IDX_W'(k);
            #1;
            if (k <= 1)          expv = 1;
            else if (k <= n_eff) expv = is_prime(k) ? 0 : 1;
            else if (k <= MAX_N) expv = 0;
            else                 expv = 1;
            chk(int'(rd_mark) == expv, "R1", $sformatf("mark of %0d (N=%0d)", k, n_eff), int'(rd_mark), expv);
        end
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog: run did not finish, actual 0 expected 1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy === 1'b0, "R9", "busy in reset", int'(busy), 0);
        chk(done === 1'b0, "R9", "done in reset", int'(done), 0);
        chk(out_valid === 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        rd_addr = IDX_W'(5);
        #1;
        chk(rd_mark === 1'b1, "R9", "flag in reset", int'(rd_mark), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(busy === 1'b0 && done === 1'b0, "R9", "idle after reset", int'(busy), 0);

        for (int n = 0; n <= MAX_N; n++) run_case(n, 1'b0);
        run_case(30, 1'b1);
        run_case(100, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule